// File: doc/BRIEF.md
# Self-Clearing Host Control Register

This block is the 32-bit read/write control word of a memory-card host controller. It lives in the bus clock domain and is written as a whole word through a one-cycle write strobe. Its readback is always available. Its plain fields drive these outputs directly from flops:
- two 4-bit regulator voltage ports
- an active-low open-drain pull-up enable
- the external-DMA and internal-DMA selects
- the card-side command flags
- the global interrupt enable.

Three bits request resets, and each clears itself on its own schedule. The DMA reset clears after a fixed count of bus cycles. The FIFO reset clears when the FIFO reports completion. The controller reset is handed across to the card clock through synchronizers and clears only after both the bus-side and the card-side minimum durations have passed. While the controller reset is active it holds the read-wait, IRQ-response and read-abort bits at 0, and it fires a one-cycle clear toward the command-start flag. Two command bits also clear themselves on card-side handshakes.

The interrupt output is a registered AND of the global enable with the OR of all pending inputs that are not masked.

Top module: `hctl_ctrl_reg`

## Requirements
- R1: After synchronous reset every field reads 0, every output is 0 except `od_pu_en_n_o`, which is 1. The reserved bits (mask 0xFC00F008: bit 3, bits 15:12, bits 31:26) always read 0.
- R2: The plain fields load from every write and read back unchanged. These are bit 4 (interrupt enable), bit 5 (external DMA), bit 6 (read wait), bit 9 (completion-signal disable), bit 10 (auto stop), bit 11 (device interrupt enable), bits 19:16 (`volt_a_o`), bits 23:20 (`volt_b_o`), bit 24 (pull-up, with `od_pu_en_n_o` its inverse) and bit 25 (internal DMA select). Each output mirrors its bit.
- R3: Writing 1 to bit 2 sets it and `dma_rst_o` for exactly 2 bus cycles. Writing 1 while the bit is set restarts nothing, and writing 0 has no effect.
- R4: Writing 1 to bit 1 sets it and `fifo_rst_o` until a cycle with `fifo_done_i` high, after which it reads 0. `fifo_done_i` while the bit is clear has no effect.
- R5: Writing 1 to bit 0 sets it. It clears by itself once at least 2 bus cycles have passed and `card_ctl_rst_o` has been high for at least 2 card-clock cycles. A further write of 1 while it is set restarts nothing.
- R6: While bit 0 reads 1, bits 8:6 read 0 and writes to them are dropped. `cmd_start_clr_o` pulses for one cycle in the first cycle bit 0 reads 1. All other fields are unaffected.
- R7: Bit 7 (IRQ response) is set by writing 1 and cleared by `resp_sent_i`. Writing 0 has no effect.
- R8: Bit 8 (read abort) is set by writing 1 and cleared by `rd_idle_i`. Writing 0 has no effect.
- R9: `irq_o` equals, one cycle later, bit 4 AND the OR of (`irq_pend_i` & `irq_mask_i`), where a mask bit of 1 lets its source through.
- R10: A write of 1 in the same cycle as a hardware clear of bits 1, 2, 7 or 8 wins. For bit 2 this starts a fresh 2-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| cclk | input | 1 | Card clock |
| crst | input | 1 | Synchronous active-high reset, card domain |
| wr_en | input | 1 | Whole-word write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| fifo_done_i | input | 1 | FIFO reset completed |
| resp_sent_i | input | 1 | IRQ response has been sent |
| rd_idle_i | input | 1 | Data state machine back in idle |
| irq_pend_i | input | NUM_IRQ | Pending interrupt sources |
| irq_mask_i | input | NUM_IRQ | Per-source enables (1 = pass) |
| irq_o | output | 1 | Gated interrupt |
| volt_a_o | output | 4 | Regulator A setting |
| volt_b_o | output | 4 | Regulator B setting |
| od_pu_en_n_o | output | 1 | Active-low open-drain pull-up enable |
| ext_dma_en_o | output | 1 | External DMA mode |
| int_dma_sel_o | output | 1 | Internal DMA path select |
| read_wait_o | output | 1 | Read-wait request |
| irq_resp_o | output | 1 | Send IRQ response request |
| abort_rd_o | output | 1 | Read abort request |
| cmpl_sig_dis_o | output | 1 | Completion-signal-disable request |
| auto_stop_o | output | 1 | Auto stop after completion-signal disable |
| dev_irq_en_o | output | 1 | Device interrupt enable status |
| dma_rst_o | output | 1 | DMA logic reset pulse |
| fifo_rst_o | output | 1 | FIFO reset request |
| cmd_start_clr_o | output | 1 | One-cycle clear for the command-start flag |
| card_ctl_rst_o | output | 1 | Controller reset in the card clock domain |

## Verification
Some invariants are checked on every cycle by the bound assertions:
- reserved bits read zero
- the pull-up output is the inverse of its bit
- bits 8:6 are held at zero and the command clear occurs only under an active controller reset
- the DMA pulse holds through its second cycle
- the FIFO and command bits hold until their handshake arrives
- the interrupt output rises only after the enable was set
- the controller reset bit stays set for at least two cycles.

Only the bench's scenarios can show other behaviour. This includes the exact clearing cycle of the DMA reset, the priority of a write over a coincident clear, that writes of 0 or repeated writes of 1 leave requests untouched, and that the controller reset ends only after the card side has held its reset for two card cycles.

// File: rtl/hctl_pkg.sv
package hctl_pkg;
  localparam int REG_W    = 32;
  localparam int VOLT_W   = 4;
  localparam int B_CRST   = 0;
  localparam int B_FIFO   = 1;
  localparam int B_DMA    = 2;
  localparam int B_IEN    = 4;
  localparam int B_XDMA   = 5;
  localparam int B_RDWAIT = 6;
  localparam int B_IRQRSP = 7;
  localparam int B_ABORT  = 8;
  localparam int B_CSD    = 9;
  localparam int B_ASTOP  = 10;
  localparam int B_DEVIE  = 11;
  localparam int B_VOLTA  = 16;
  localparam int B_VOLTB  = 20;
  localparam int B_ODPU   = 24;
  localparam int B_IDMA   = 25;
  // fields that load directly from any write (read wait is handled apart)
  localparam logic [REG_W-1:0] PLAIN_MASK = 32'h03FF_0E30;
  // every implemented bit
  localparam logic [REG_W-1:0] USED_MASK  = 32'h03FF_0FF7;
  localparam logic [REG_W-1:0] RESV_MASK  = ~USED_MASK;
endpackage

// File: rtl/hctl_sync.sv
module hctl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_i};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d_i;
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hctl_pulse_hold.sv
module hctl_pulse_hold #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  output logic busy_o
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

  logic [CW-1:0] cnt;
  logic          last;
  logic          start;

  assign last  = busy_o && (cnt == CW'(HOLD - 1));
  assign start = set_i && (!busy_o || last);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      busy_o <= 1'b1;
      cnt    <= '0;
    end else if (last) begin
      busy_o <= 1'b0;
      cnt    <= '0;
    end else if (busy_o) begin
      cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hctl_crst_xdom.sv
module hctl_crst_xdom #(
  parameter int BUS_CYC     = 2,
  parameter int CARD_CYC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cclk,
  input  logic crst,
  input  logic set_i,
  output logic bit_o,
  output logic start_o,
  output logic card_rst_o
);
  localparam int BW  = $clog2(BUS_CYC + 1);
  localparam int CCW = (CARD_CYC > 1) ? $clog2(CARD_CYC) : 1;

  // bus side
  logic          arm_q;
  logic [BW-1:0] bcnt;
  logic          ack_s;
  logic          done;

  assign done    = bit_o && arm_q && ack_s && (bcnt == BW'(BUS_CYC));
  assign start_o = set_i && (!bit_o || done);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_o <= 1'b0;
      arm_q <= 1'b0;
      bcnt  <= '0;
    end else if (start_o) begin
      bit_o <= 1'b1;
      arm_q <= !ack_s;
      bcnt  <= '0;
    end else if (done) begin
      bit_o <= 1'b0;
      arm_q <= 1'b0;
    end else if (bit_o) begin
      arm_q <= arm_q || !ack_s;
      if (bcnt != BW'(BUS_CYC)) bcnt <= bcnt + 1'b1;
    end
  end

  // card side
  logic           req_s;
  logic [CCW-1:0] ccnt;
  logic           ack_q;

  hctl_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk (cclk),
    .rst (crst),
    .d_i (arm_q),
    .q_o (req_s)
  );

  always_ff @(posedge cclk) begin
    if (crst || !req_s) begin
      ccnt  <= '0;
      ack_q <= 1'b0;
    end else if (!ack_q) begin
      if (ccnt == CCW'(CARD_CYC - 1)) ack_q <= 1'b1;
      else                            ccnt  <= ccnt + 1'b1;
    end
  end

  assign card_rst_o = req_s;

  hctl_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk (clk),
    .rst (rst),
    .d_i (ack_q),
    .q_o (ack_s)
  );
endmodule

// File: rtl/hctl_irq_gate.sv
module hctl_irq_gate #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= en_i && (|(pend_i & mask_i));
  end
endmodule

// File: rtl/hctl_ctrl_reg.sv
module hctl_ctrl_reg
  import hctl_pkg::*;
#(
  parameter int NUM_IRQ      = 16,
  parameter int DMA_HOLD     = 2,
  parameter int CRST_BUS_CYC = 2,
  parameter int CRST_CRD_CYC = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cclk,
  input  logic               crst,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  input  logic               fifo_done_i,
  input  logic               resp_sent_i,
  input  logic               rd_idle_i,
  input  logic [NUM_IRQ-1:0] irq_pend_i,
  input  logic [NUM_IRQ-1:0] irq_mask_i,
  output logic               irq_o,
  output logic [3:0]         volt_a_o,
  output logic [3:0]         volt_b_o,
  output logic               od_pu_en_n_o,
  output logic               ext_dma_en_o,
  output logic               int_dma_sel_o,
  output logic               read_wait_o,
  output logic               irq_resp_o,
  output logic               abort_rd_o,
  output logic               cmpl_sig_dis_o,
  output logic               auto_stop_o,
  output logic               dev_irq_en_o,
  output logic               dma_rst_o,
  output logic               fifo_rst_o,
  output logic               cmd_start_clr_o,
  output logic               card_ctl_rst_o
);
  logic [REG_W-1:0] plain_q;
  logic             rdwait_q, irqrsp_q, abort_q, fifo_q, odn_q, cmdclr_q;
  logic             crst_bit, crst_start, hold_sib;

  // controller reset with card-domain handshake
  hctl_crst_xdom #(
    .BUS_CYC     (CRST_BUS_CYC),
    .CARD_CYC    (CRST_CRD_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_crst (
    .clk        (clk),
    .rst        (rst),
    .cclk       (cclk),
    .crst       (crst),
    .set_i      (wr_en && wr_data[B_CRST]),
    .bit_o      (crst_bit),
    .start_o    (crst_start),
    .card_rst_o (card_ctl_rst_o)
  );

  // counted DMA reset
  hctl_pulse_hold #(.HOLD(DMA_HOLD)) u_dma (
    .clk    (clk),
    .rst    (rst),
    .set_i  (wr_en && wr_data[B_DMA]),
    .busy_o (dma_rst_o)
  );

  assign hold_sib = crst_bit || crst_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      plain_q <= '0;
      odn_q   <= 1'b1;
    end else if (wr_en) begin
      plain_q <= wr_data & PLAIN_MASK;
      odn_q   <= !wr_data[B_ODPU];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           rdwait_q <= 1'b0;
    else if (hold_sib) rdwait_q <= 1'b0;
    else if (wr_en)    rdwait_q <= wr_data[B_RDWAIT];
  end

  always_ff @(posedge clk) begin
    if (rst)                            irqrsp_q <= 1'b0;
    else if (hold_sib)                  irqrsp_q <= 1'b0;
    else if (wr_en && wr_data[B_IRQRSP]) irqrsp_q <= 1'b1;
    else if (resp_sent_i)               irqrsp_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                           abort_q <= 1'b0;
    else if (hold_sib)                 abort_q <= 1'b0;
    else if (wr_en && wr_data[B_ABORT]) abort_q <= 1'b1;
    else if (rd_idle_i)                abort_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                          fifo_q <= 1'b0;
    else if (wr_en && wr_data[B_FIFO]) fifo_q <= 1'b1;
    else if (fifo_done_i)             fifo_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) cmdclr_q <= 1'b0;
    else     cmdclr_q <= crst_start;
  end

  hctl_irq_gate #(.N(NUM_IRQ)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .en_i   (plain_q[B_IEN]),
    .pend_i (irq_pend_i),
    .mask_i (irq_mask_i),
    .irq_o  (irq_o)
  );

  always_comb begin
    rd_data           = plain_q;
    rd_data[B_CRST]   = crst_bit;
    rd_data[B_FIFO]   = fifo_q;
    rd_data[B_DMA]    = dma_rst_o;
    rd_data[B_RDWAIT] = rdwait_q;
    rd_data[B_IRQRSP] = irqrsp_q;
    rd_data[B_ABORT]  = abort_q;
  end

  assign volt_a_o        = plain_q[B_VOLTA +: VOLT_W];
  assign volt_b_o        = plain_q[B_VOLTB +: VOLT_W];
  assign od_pu_en_n_o    = odn_q;
  assign ext_dma_en_o    = plain_q[B_XDMA];
  assign int_dma_sel_o   = plain_q[B_IDMA];
  assign read_wait_o     = rdwait_q;
  assign irq_resp_o      = irqrsp_q;
  assign abort_rd_o      = abort_q;
  assign cmpl_sig_dis_o  = plain_q[B_CSD];
  assign auto_stop_o     = plain_q[B_ASTOP];
  assign dev_irq_en_o    = plain_q[B_DEVIE];
  assign fifo_rst_o      = fifo_q;
  assign cmd_start_clr_o = cmdclr_q;
endmodule

// File: rtl/hctl_ctrl_reg_chk.sv
module hctl_ctrl_reg_chk
  import hctl_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] rd_data,
  input logic        od_n,
  input logic        dma_rst,
  input logic        fifo_rst,
  input logic        fifo_done,
  input logic        cmd_clr,
  input logic        irq,
  input logic        resp_sent,
  input logic        rd_idle,
  input logic        wr_en,
  input logic        wr_d0
);
  assert_resv_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_data & RESV_MASK) == '0);

  assert_odpu_inv_R2: assert property (@(posedge clk) disable iff (rst)
    od_n == !rd_data[B_ODPU]);

  assert_dma_second_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_rst) |=> dma_rst);

  assert_fifo_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (fifo_rst && !fifo_done) |=> fifo_rst);

  assert_crst_min_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_data[B_CRST]) |-> $past(rd_data[B_CRST], 2));

  assert_sib_zero_R6: assert property (@(posedge clk) disable iff (rst)
    rd_data[B_CRST] |-> (rd_data[8:6] == 3'b000));

  assert_cmdclr_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_clr |-> rd_data[B_CRST]);

  assert_irqrsp_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_data[B_IRQRSP] && !resp_sent && !(wr_en && wr_d0)) |=> rd_data[B_IRQRSP]);

  assert_abort_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_data[B_ABORT] && !rd_idle && !(wr_en && wr_d0)) |=> rd_data[B_ABORT]);

  assert_irq_en_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(rd_data[B_IEN]));
endmodule

bind hctl_ctrl_reg hctl_ctrl_reg_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_data   (rd_data),
  .od_n      (od_pu_en_n_o),
  .dma_rst   (dma_rst_o),
  .fifo_rst  (fifo_rst_o),
  .fifo_done (fifo_done_i),
  .cmd_clr   (cmd_start_clr_o),
  .irq       (irq_o),
  .resp_sent (resp_sent_i),
  .rd_idle   (rd_idle_i),
  .wr_en     (wr_en),
  .wr_d0     (wr_data[0])
);

// File: tb/sim_hctl_ctrl_reg.sv
module sim_hctl_ctrl_reg;
  localparam int CLK_PERIOD  = 10;
  localparam int CCLK_PERIOD = 16;
  localparam int NIRQ        = 16;
  localparam int WDOG        = 20000;
  localparam logic [31:0] PLAIN = 32'h03FF_0E70; // plain fields incl. read wait
  localparam logic [31:0] RESV  = 32'hFC00_F008;

  logic clk = 0, cclk = 0, rst = 1, crst = 1;
  logic wr_en = 0;
  logic [31:0] wr_data = 0;
  logic fifo_done = 0, resp_sent = 0, rd_idle = 0;
  logic [NIRQ-1:0] pend = 0, mask = 0;
  logic [31:0] rd_data;
  logic irq_o, odn, xdma, idma, rdw, irsp, abrt, csd, astop, devie, dmar, fifor, cmdclr, cardr;
  logic [3:0] va, vb;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(CCLK_PERIOD/2) cclk = ~cclk;

  hctl_ctrl_reg #(.NUM_IRQ(NIRQ)) u0 (
    .clk(clk), .rst(rst), .cclk(cclk), .crst(crst),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .fifo_done_i(fifo_done), .resp_sent_i(resp_sent), .rd_idle_i(rd_idle),
    .irq_pend_i(pend), .irq_mask_i(mask), .irq_o(irq_o),
    .volt_a_o(va), .volt_b_o(vb), .od_pu_en_n_o(odn),
    .ext_dma_en_o(xdma), .int_dma_sel_o(idma), .read_wait_o(rdw),
    .irq_resp_o(irsp), .abort_rd_o(abrt), .cmpl_sig_dis_o(csd),
    .auto_stop_o(astop), .dev_irq_en_o(devie), .dma_rst_o(dmar),
    .fifo_rst_o(fifor), .cmd_start_clr_o(cmdclr), .card_ctl_rst_o(cardr)
  );

  int total = 0, bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // reference model state
  logic [31:0] m = 0;
  int mcnt = 0;
  logic m_irq = 0, m_cmd = 0;
  int bcount = 0, ccount = 0, cbase = 0;

  always @(negedge cclk) if (cardr) ccount++;

  always @(posedge clk) begin
    logic [31:0] nx;
    logic force0, dstart, dclear, ncmd, nirq;
    if (rst) begin
      m = 0; mcnt = 0; m_irq = 0; m_cmd = 0; bcount = 0;
    end else begin
      nx = m;
      force0 = m[0] | (wr_en & wr_data[0]);
      if (wr_en) nx = (m & ~PLAIN) | (wr_data & PLAIN);
      if (force0) nx[8:6] = 3'b000;
      else begin
        nx[7] = (wr_en & wr_data[7]) ? 1'b1 : (resp_sent ? 1'b0 : m[7]);
        nx[8] = (wr_en & wr_data[8]) ? 1'b1 : (rd_idle ? 1'b0 : m[8]);
      end
      nx[1] = (wr_en & wr_data[1]) ? 1'b1 : (fifo_done ? 1'b0 : m[1]);
      dclear = m[2] && (mcnt == 1);
      dstart = wr_en && wr_data[2] && (!m[2] || dclear);
      if (dstart) begin nx[2] = 1; mcnt = 0; end
      else if (dclear) begin nx[2] = 0; mcnt = 0; end
      else if (m[2]) mcnt++;
      ncmd = wr_en & wr_data[0] & !m[0];
      if (wr_en & wr_data[0]) nx[0] = 1'b1;
      nirq = m[4] & (|(pend & mask));
      if (ncmd) begin bcount = 0; cbase = ccount; end
      else if (m[0]) bcount++;
      #1;
      if (m[0] && nx[0] && !rd_data[0]) begin
        // R5: self-clear allowed only after both minimum durations
        chk("R5 bus cycles", (bcount >= 2), 1);
        chk("R5 card cycles", ((ccount - cbase) >= 2), 1);
        nx[0] = 1'b0;
      end
      if (nx[0] && bcount == 80) chk("R5 clear timeout", 0, 1);
      m = nx; m_cmd = ncmd; m_irq = nirq;
      chk("R1", rd_data & RESV, 0);
      chk("R2", rd_data & PLAIN, m & PLAIN);
      chk("R2", {vb, va, odn, xdma, idma, rdw, csd, astop, devie},
                {m[23:20], m[19:16], !m[24], m[5], m[25], m[6], m[9], m[10], m[11]});
      chk("R3", {rd_data[2], dmar}, {m[2], m[2]});
      chk("R4", {rd_data[1], fifor}, {m[1], m[1]});
      chk("R5", rd_data[0], m[0]);
      chk("R6", cmdclr, m_cmd);
      chk("R7", {rd_data[7], irsp}, {m[7], m[7]});
      chk("R8", {rd_data[8], abrt}, {m[8], m[8]});
      chk("R9", irq_o, m_irq);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      bad++; total++;
      $display("FAIL watchdog (all requirements): actual=%0d expected<=%0d", cyc, WDOG);
      finish_run();
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_in(input int which);
    @(negedge clk);
    if (which == 0) fifo_done = 1; else if (which == 1) resp_sent = 1; else rd_idle = 1;
    @(negedge clk); fifo_done = 0; resp_sent = 0; rd_idle = 0;
  endtask

  task automatic wait_crst();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!rd_data[0]) break;
    end
  endtask

  initial begin
    logic [31:0] lf;
    repeat (6) @(negedge clk);
    rst = 0; crst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset value", rd_data, 0);
    chk("R1 pull-up n", odn, 1);

    // R2 plain fields, several patterns
    wr(32'h0155_0A30); idle(1);
    chk("R2 volt_a", va, 4'h5);
    wr(32'h02AA_0450); idle(1);
    chk("R2 pull-up n", odn, 1'b1);
    wr(32'hFC00_F008); idle(1);
    chk("R1 reserved only write", rd_data, 0);

    // R3 DMA reset, repeat write ignored, write 0 no effect
    wr(32'h4); wr(32'h4); idle(4);
    wr(32'h4); wr(32'h0); idle(3);
    // R10 write coincident with DMA clear cycle
    wr(32'h4); idle(0); wr(32'h4);
    chk("R10 dma restart", rd_data[2], 1);
    idle(4);

    // R4 FIFO reset handshake
    wr(32'h2); idle(3); pulse_in(0); idle(2);
    pulse_in(0); idle(1);
    wr(32'h2); idle(1);
    @(negedge clk); fifo_done = 1; wr_en = 1; wr_data = 32'h2;
    @(negedge clk); fifo_done = 0; wr_en = 0;
    chk("R10 fifo write wins", rd_data[1], 1);
    pulse_in(0); idle(2);

    // R7 IRQ response
    wr(32'h80); idle(2); wr(32'h0);
    chk("R7 write 0 ignored", rd_data[7], 1);
    pulse_in(1); idle(1);
    wr(32'h80);
    @(negedge clk); resp_sent = 1; wr_en = 1; wr_data = 32'h80;
    @(negedge clk); resp_sent = 0; wr_en = 0;
    chk("R10 irq resp write wins", rd_data[7], 1);
    pulse_in(1); idle(1);

    // R8 read abort
    wr(32'h100); idle(2); wr(32'h0);
    chk("R8 write 0 ignored", rd_data[8], 1);
    pulse_in(2); idle(2);

    // R5/R6 controller reset with side effects
    wr(32'h0000_01D0); idle(1);
    wr(32'h0000_01D1); idle(1);
    chk("R6 siblings held", rd_data[8:6], 0);
    wr(32'h0000_01D1);
    chk("R6 int enable kept", rd_data[4], 1);
    wait_crst();
    chk("R5 cleared", rd_data[0], 0);
    wr(32'h0000_0011); // new request while handshake tail still settling
    wait_crst();
    chk("R5 second clear", rd_data[0], 0);
    idle(20);

    // R9 interrupt gating
    wr(32'h10);
    @(negedge clk); pend = 16'h0004; mask = 16'h0000;
    idle(2); chk("R9 masked", irq_o, 0);
    mask = 16'h0004; idle(2); chk("R9 passed", irq_o, 1);
    pend = 16'h8000; idle(2);
    mask = 16'hFFFF; idle(2);
    wr(32'h0); idle(2); chk("R9 global off", irq_o, 0);
    wr(32'h10); idle(2);

    // mixed stretch, no controller reset requests
    lf = 32'hACE1_2357;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      wr_en = lf[3] & lf[9];
      wr_data = {lf[7:0], lf[31:8]} & 32'hFFFF_FFFE;
      fifo_done = lf[12] & lf[5];
      resp_sent = lf[14] & lf[2];
      rd_idle = lf[17] & lf[11];
      pend = lf[15:0];
      mask = lf[31:16];
    end
    @(negedge clk);
    wr_en = 0; fifo_done = 0; resp_sent = 0; rd_idle = 0;
    idle(5);
    finish_run();
  end
endmodule